// File: doc/BRIEF.md
# Scanline Pixel Fetcher

This block turns one row of an external asynchronous byte-wide SRAM into a run of pixels on a parallel video bus. A one-clock line strobe marks the start of each scanline. The block then counts a fixed lead-in. When the lead-in ends, the active region opens. During the active region the block keeps the SRAM read strobes asserted and moves through the pixel columns of the selected row. Each column address is held for a fixed number of clocks. The byte read at that address goes to the video bus unchanged: there is no palette or lookup.

The row number is captured at the same clock as the line strobe. It forms the upper part of the SRAM address, and the pixel column counter forms the lower byte. After the last pixel, the final pixel value stays on the bus until the active region ends. Outside the active region the bus carries a background level supplied by the user. Sync, blanking, colour encoding and the DAC are handled elsewhere.

Top module: `scanline_pixel_fetch`

## Requirements
- R1: `sram_addr` is the row captured at the line-strobe edge in bits [14:8], above the 8-bit pixel column in bits [7:0].
- R2: `sram_ce_n` and `sram_oe_n` are both low for exactly ACTIVE_CLKS consecutive clocks. This window starts LEAD_CLKS rising edges after the edge that samples `line_start`. At all other times both are high.
- R3: On the first clock of the active region the column is 0.
- R4: The column advances by exactly one every PIX_CLKS clocks of the active region. It stops at NUM_PIX and never exceeds it.
- R5: For pixel k, the SRAM byte at column k appears on `video_out` unchanged. It appears one clock after column k is first presented and stays for PIX_CLKS clocks.
- R6: From the end of the last pixel period until one clock after the active region closes, `video_out` keeps the byte of column NUM_PIX-1.
- R7: Outside the active region, `video_out` shows `bg_level` with one clock of delay. The address column does not move while the active region is closed.
- R8: A `line_start` pulse in any phase, including the lead-in or the active region, restarts the lead-in from its full length.
- R9: While `rst_n` is low, on a clock edge the strobes go high, the address goes to 0 and `video_out` goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | One-clock scanline start strobe |
| row_sel | input | ROW_W (7) | Row to fetch, captured with the strobe |
| bg_level | input | PIX_W (8) | Level driven outside the active region |
| sram_data | input | PIX_W (8) | SRAM read data |
| sram_addr | output | ROW_W+COL_W (15) | SRAM address: row above column |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| video_out | output | PIX_W (8) | Registered pixel byte to the video path |

## Verification
The bench targets several corner cases, each of which a wrong design would show in a specific way:
- Off-by-one edges of the lead-in and active windows. A wrong count would open the strobes a clock early or late, or drop the last pixel clock.
- The one-clock pixel pipeline. An error there would show column k's byte during column k+1's period, or latch the junk the SRAM drives while disabled.
- The padding tail after the last pixel. A wrong design would keep advancing the column past NUM_PIX or fall back to the background early.
- Strobes that arrive mid lead-in and mid active region. A design that ignored them, or resumed the old count, would open the window at the wrong clock.

// File: rtl/scanline_fetch_pkg.sv
// Shared types for the scanline pixel fetcher.
package scanline_fetch_pkg;

    // Phase of the scanline as seen by the fetcher.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LEAD   = 2'd1,
        PH_ACTIVE = 2'd2
    } line_phase_e;

endpackage

// File: rtl/sf_line_timer.sv
// Line timer: after a line strobe it counts LEAD_CLKS clocks, then holds
// act_o high for ACTIVE_CLKS clocks. A strobe in any phase restarts the
// lead-in. Assumes LEAD_CLKS >= 1 and ACTIVE_CLKS >= 1.
module sf_line_timer
    import scanline_fetch_pkg::*;
#(
    parameter int LEAD_CLKS   = 872,
    parameter int ACTIVE_CLKS = 4208
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    output logic act_o,
    output logic act_start_o
);

    localparam int CNT_MAX = (LEAD_CLKS > ACTIVE_CLKS) ? LEAD_CLKS : ACTIVE_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    line_phase_e      phase_q;
    logic [CNT_W-1:0] cnt_q;

    // Phase sequencing and the down-counter for the current window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (line_start) begin
            phase_q <= PH_LEAD;
            cnt_q   <= CNT_W'(LEAD_CLKS - 1);
        end else begin
            case (phase_q)
                PH_LEAD: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_ACTIVE;
                        cnt_q   <= CNT_W'(ACTIVE_CLKS - 1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    // Decoded phase flags for the stepper and the output stage.
    always_comb begin
        act_o       = (phase_q == PH_ACTIVE);
        act_start_o = (phase_q == PH_LEAD) && (cnt_q == '0) && !line_start;
    end

    AST_ACTIVE_ONLY_FROM_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_o) |-> $past(act_start_o)); // R2

    AST_STROBE_CLOSES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !act_o); // R8

endmodule

// File: rtl/sf_pixel_stepper.sv
// Pixel stepper: zeroes the column on entry to the active region. It then
// advances the column once every PIX_CLKS clocks until NUM_PIX pixels have
// been stepped through, and flags the first clock of each pixel period so
// the output stage can capture it. Assumes NUM_PIX < 2**COL_W and
// PIX_CLKS >= 1.
module sf_pixel_stepper #(
    parameter int COL_W    = 8,
    parameter int NUM_PIX  = 16,
    parameter int PIX_CLKS = 263
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             act_start_i,
    output logic [COL_W-1:0] col_o,
    output logic             sample_o
);

    localparam int PC_W = (PIX_CLKS > 1) ? $clog2(PIX_CLKS) : 1;

    logic [COL_W-1:0] col_q;
    logic [PC_W-1:0]  pc_q;
    logic             more_pix;

    // Whether the line still has pixels to step through.
    always_comb more_pix = (col_q < COL_W'(NUM_PIX));

    // Column and in-pixel clock counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            pc_q  <= '0;
        end else if (act_start_i) begin
            col_q <= '0;
            pc_q  <= '0;
        end else if (act_i && more_pix) begin
            if (pc_q == PC_W'(PIX_CLKS - 1)) begin
                pc_q  <= '0;
                col_q <= col_q + COL_W'(1);
            end else begin
                pc_q <= pc_q + PC_W'(1);
            end
        end
    end

    // Outputs: current column, and the capture flag for each new pixel.
    always_comb begin
        col_o    = col_q;
        sample_o = act_i && (pc_q == '0) && more_pix;
    end

    AST_COL_ZERO_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_i) |-> (col_o == '0)); // R3

    AST_COL_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && $past(act_i) && (col_o != $past(col_o))) |-> (col_o == $past(col_o) + COL_W'(1))); // R4

    AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> (col_o <= COL_W'(NUM_PIX))); // R4

    AST_COL_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_i && !$past(act_i) && $past(rst_n)) |-> $stable(col_o)); // R7

endmodule

// File: rtl/sf_video_out.sv
// Video output register: in the active region it captures the SRAM byte
// on each pixel's first clock and holds it otherwise. Outside the active
// region it follows the background level. Assumes the SRAM data is valid
// one clock after the address changes.
module sf_video_out #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             sample_i,
    input  logic [PIX_W-1:0] sram_data_i,
    input  logic [PIX_W-1:0] bg_level_i,
    output logic [PIX_W-1:0] video_o
);

    logic [PIX_W-1:0] video_q;

    // Select and register the byte shown on the video bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            video_q <= '0;
        end else if (!act_i) begin
            video_q <= bg_level_i;
        end else if (sample_i) begin
            video_q <= sram_data_i;
        end
    end

    // Drive the port from the register.
    always_comb video_o = video_q;

    AST_PIXEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sample_i) && $past(rst_n)) |-> (video_o == $past(sram_data_i))); // R5

    AST_HOLD_BETWEEN_PIXELS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act_i) && !$past(sample_i) && $past(rst_n)) |-> $stable(video_o)); // R6

    AST_BG_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(act_i) && $past(rst_n)) |-> (video_o == $past(bg_level_i))); // R7

endmodule

// File: rtl/scanline_pixel_fetch.sv
// Scanline pixel fetcher top. It captures the row with the line strobe and
// forms the SRAM address from that row and the pixel column. It holds the
// SRAM read strobes low for the whole active region and passes fetched
// bytes to the video bus. Assumes an asynchronous SRAM whose read data is
// valid within one clock of an address change while both strobes are low.
module scanline_pixel_fetch #(
    parameter int ROW_W       = 7,
    parameter int COL_W       = 8,
    parameter int PIX_W       = 8,
    parameter int NUM_PIX     = 16,
    parameter int LEAD_CLKS   = 872,
    parameter int ACTIVE_CLKS = 4208,
    parameter int PIX_CLKS    = 263
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_start,
    input  logic [ROW_W-1:0]       row_sel,
    input  logic [PIX_W-1:0]       bg_level,
    input  logic [PIX_W-1:0]       sram_data,
    output logic [ROW_W+COL_W-1:0] sram_addr,
    output logic                   sram_ce_n,
    output logic                   sram_oe_n,
    output logic [PIX_W-1:0]       video_out
);

    localparam int ADDR_W = ROW_W + COL_W;

    logic             act;
    logic             act_start;
    logic             sample;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row_q;

    sf_line_timer #(
        .LEAD_CLKS   (LEAD_CLKS),
        .ACTIVE_CLKS (ACTIVE_CLKS)
    ) timer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (line_start),
        .act_o       (act),
        .act_start_o (act_start)
    );

    sf_pixel_stepper #(
        .COL_W    (COL_W),
        .NUM_PIX  (NUM_PIX),
        .PIX_CLKS (PIX_CLKS)
    ) stepper_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act),
        .act_start_i (act_start),
        .col_o       (col),
        .sample_o    (sample)
    );

    sf_video_out #(
        .PIX_W (PIX_W)
    ) vout_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act),
        .sample_i    (sample),
        .sram_data_i (sram_data),
        .bg_level_i  (bg_level),
        .video_o     (video_out)
    );

    // Capture the row for the coming line together with the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (line_start) begin
            row_q <= row_sel;
        end
    end

    // SRAM address and read strobes.
    always_comb begin
        sram_addr = {row_q, col};
        sram_ce_n = !act;
        sram_oe_n = !act;
    end

    AST_ROW_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (sram_addr[ADDR_W-1:COL_W] == $past(row_sel))); // R1

    AST_ROW_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(line_start) && $past(rst_n)) |-> $stable(sram_addr[ADDR_W-1:COL_W])); // R1

endmodule

// File: tb/scanline_pixel_fetch_tb_top.sv
`timescale 1ns/1ps
module scanline_pixel_fetch_tb_top;

    localparam int D = 10;
    localparam int A = 70;
    localparam int P = 4;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [6:0]  row_sel = '0;
    logic [7:0]  bg_level = '0;
    logic [7:0]  sram_data;
    logic [14:0] sram_addr;
    logic        sram_ce_n;
    logic        sram_oe_n;
    logic [7:0]  video_out;
    logic [7:0]  key_q = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    scanline_pixel_fetch #(
        .NUM_PIX     (N),
        .LEAD_CLKS   (D),
        .ACTIVE_CLKS (A),
        .PIX_CLKS    (P)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .row_sel    (row_sel),
        .bg_level   (bg_level),
        .sram_data  (sram_data),
        .sram_addr  (sram_addr),
        .sram_ce_n  (sram_ce_n),
        .sram_oe_n  (sram_oe_n),
        .video_out  (video_out)
    );

    // Content of the emulated SRAM, varied per line by the key.
    function automatic logic [7:0] pix_val(input logic [14:0] a, input logic [7:0] key);
        logic [15:0] t;
        t = {8'd0, a[7:0]} * 16'd29;
        return t[7:0] ^ {1'b0, a[14:8]} ^ key;
    endfunction

    // Asynchronous SRAM model: junk while not enabled.
    always_comb sram_data = (sram_ce_n || sram_oe_n) ? 8'hEE : pix_val(sram_addr, key_q);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Pulse the strobe, then check every clock up to n == stop.
    task automatic run_line(input logic [6:0] row, input logic [7:0] bg,
                            input logic [7:0] key, input int stop, input string ctx);
        logic [14:0] addr0;
        @(negedge clk);
        line_start = 1'b1;
        row_sel    = row;
        bg_level   = bg;
        key_q      = key;
        @(posedge clk);
        @(negedge clk);
        line_start = 1'b0;
        row_sel    = 7'($urandom);
        addr0      = sram_addr;
        for (int n = 0; n <= stop; n++) begin
            logic exp_act;
            int   k;
            exp_act = (n >= D) && (n < D + A);
            chk({"R2 ce_n ", ctx}, 32'(sram_ce_n), 32'(!exp_act));
            chk({"R2 oe_n ", ctx}, 32'(sram_oe_n), 32'(!exp_act));
            chk({"R1 row ", ctx}, 32'(sram_addr[14:8]), 32'(row));
            if (n < D) chk({"R7 addr hold ", ctx}, 32'(sram_addr), 32'(addr0));
            if (exp_act) begin
                k = (n - D) / P;
                if (k > N) k = N;
                if (n == D) chk({"R3 col zero ", ctx}, 32'(sram_addr[7:0]), 0);
                else        chk({"R4 col step ", ctx}, 32'(sram_addr[7:0]), 32'(k));
            end
            if (n >= 1 && n <= D) begin
                chk({"R7 lead bg ", ctx}, 32'(video_out), 32'(bg));
            end else if (n > D && n <= D + A) begin
                k = (n - D - 1) / P;
                if (k >= N) chk({"R6 pad hold ", ctx}, 32'(video_out), 32'(pix_val({row, 8'(N - 1)}, key)));
                else        chk({"R5 pixel ", ctx}, 32'(video_out), 32'(pix_val({row, 8'(k)}, key)));
            end else if (n > D + A) begin
                chk({"R7 tail bg ", ctx}, 32'(video_out), 32'(bg));
            end
            if (n < stop) @(negedge clk);
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 ce_n reset", 32'(sram_ce_n), 1);
        chk("R9 oe_n reset", 32'(sram_oe_n), 1);
        chk("R9 addr reset", 32'(sram_addr), 0);
        chk("R9 video reset", 32'(video_out), 0);
        rst_n = 1'b1;
        bg_level = 8'h3C;
        repeat (2) @(negedge clk);
        chk("R7 idle bg", 32'(video_out), 32'h3C);
        // Directed corners: extreme rows and keys.
        run_line(7'h00, 8'h10, 8'h00, D + A + 2, "first");
        run_line(7'h7F, 8'hFF, 8'hA5, D + A + 2, "last row");
        // Random lines.
        for (int i = 0; i < 8; i++) begin
            run_line(7'($urandom), 8'($urandom), 8'($urandom), D + A + 2, "random");
        end
        // R8: restart during the lead-in, then during the active region.
        run_line(7'h15, 8'h22, 8'h5A, 5, "pre R8");
        run_line(7'h2A, 8'h44, 8'h33, D + 20, "R8 lead restart");
        run_line(7'h31, 8'h66, 8'hC3, D + A + 2, "R8 active restart");
        // Idle after the line: column frozen, background followed.
        bg_level = 8'h99;
        repeat (3) @(negedge clk);
        chk("R7 idle bg change", 32'(video_out), 32'h99);
        chk("R7 idle col frozen", 32'(sram_addr[7:0]), 32'(N));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R2: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule